// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block is the watchdog of a small microcontroller core. It counts ticks from one of two sources: an always-running subsystem tick, or the instruction-clock enable. The count has a fixed binary stage of `PRE_BITS` bits (8 by default, a divide by 256). A software-selected power-of-two stage follows it, and reaches a further ratio of 1:128 when its select field is all ones. A time-out in normal run requests a full chip reset. A time-out while the core is halted requests a warm reset, which only restarts the program counter and stack pointer.

The block also keeps the two status flags that software reads after any restart to learn its cause: a time-out flag and a power-down flag. Clear commands restart the count. A configuration pin chooses between two clear schemes. In the first, a single clear command restarts the count. In the second, the count restarts only after two different clear commands have both been given. A disable pin turns every watchdog action into a no-op. The oscillators, the CPU and the reset distribution are outside this block, and strobes stand in for them.

Top module: `wdog_cause`

## Requirements
- R1: After power-on reset the time-out flag and the power-down flag are both 0, the option register reads 0x07, and neither reset output is asserted.
- R2: With select field `sel` in option bits 2:0, a chip or warm reset follows exactly 2^(PRE_BITS+sel) accepted ticks counted from a cleared count. The reset output is high in the cycle after the edge that accepts the last tick.
- R3: Option bits 7:3 are user flags. They read back as written and do not change the time-out period.
- R4: A time-out outside halt pulses `chipRst` for one cycle, sets the time-out flag, leaves the power-down flag unchanged and restarts the count. `chipRst` and `warmRst` are never high together.
- R5: A halt request outside halt clears the count, sets the power-down flag, clears the time-out flag and enters halt.
- R6: A time-out during halt pulses `warmRst` for one cycle, leaves halt, and leaves both flags at 1 (encoding 11 read as {time-out, power-down}).
- R7: An external reset request clears the count and leaves halt, and it changes neither flag. A wake from halt by external reset therefore reads 01, and an external reset in normal run keeps whatever the flags held before.
- R8: In single-clear mode (`dblClrMode`=0), `clrCmd` clears the count and the time-out flag, and `clr1`/`clr2` have no effect.
- R9: In double-clear mode (`dblClrMode`=1), the count and the time-out flag clear only once both `clr1` and `clr2` have arrived, in either order. A repeated single command does nothing, and `clrCmd` is ignored. The record of commands is dropped whenever the count is cleared.
- R10: With the instruction source selected (`srcSel`=1), ticks are not counted during halt. With the subsystem source (`srcSel`=0), counting continues during halt.
- R11: While `wdtDisable` is 1, the count does not advance, no reset output is asserted, and clear commands leave the time-out flag unchanged.
- R12: A wake request during halt leaves halt without clearing the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstPorN | input | 1 | Asynchronous power-on reset, active low |
| srcSel | input | 1 | Tick source: 0 subsystem tick, 1 instruction clock |
| subTick | input | 1 | Subsystem tick enable |
| instrTick | input | 1 | Instruction clock enable |
| wdtDisable | input | 1 | Configuration: disable all watchdog actions |
| dblClrMode | input | 1 | Configuration: two-command clear scheme |
| clrCmd | input | 1 | Single clear command strobe |
| clr1 | input | 1 | First of the paired clear commands |
| clr2 | input | 1 | Second of the paired clear commands |
| haltReq | input | 1 | Halt instruction strobe |
| wakeReq | input | 1 | Interrupt or port wake strobe |
| extRstReq | input | 1 | External reset strobe |
| optWe | input | 1 | Option register write enable |
| optWdata | input | 8 | Option register write data |
| optRdata | output | 8 | Option register read data |
| chipRst | output | 1 | Full chip reset request pulse |
| warmRst | output | 1 | Warm reset (PC and SP) request pulse |
| flagTo | output | 1 | Time-out status flag |
| flagPd | output | 1 | Power-down status flag |
| halted | output | 1 | Core is in halt |

## Verification
The bench sweeps every select value under both tick sources and counts the ticks up to the reset pulse. An off-by-one in the compare or a misplaced shift in the prescaler would show up as a period other than a power of two, or as the wrong power. In double-clear mode it repeats one command and also reverses the order of the two. A design that cleared on any single command, or that lost its record between the two commands, would return the wrong number of remaining ticks. It goes through each reset cause and reads the flag pair after it, which catches a time-out that sets the wrong reset output in halt and an external reset that disturbs the flags. It also halts with the instruction source selected, where a design that kept counting would fire a warm reset. Last, it holds the disable pin while the time-out flag is set, so a clear that still acted would show.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic tickEn;
  } wdog_stb_t;

  localparam logic [7:0] OPT_RESET = 8'h07;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int PRE_BITS = 8,
  parameter int SEL_W    = 3
) (
  input  logic       clk,
  input  logic       rstPorN,
  input  wdog_stb_t  stb,
  input  logic       optWe,
  input  logic [7:0] optWdata,
  output logic [7:0] optRdata,
  output logic       tmo
);
  localparam int MAX_SHIFT = PRE_BITS + (1 << SEL_W) - 1;
  localparam int CNT_W     = MAX_SHIFT;

  logic [7:0]       optReg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   limitW;
  logic [SEL_W-1:0] sel;

  assign sel      = optReg[SEL_W-1:0];
  assign optRdata = optReg;

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)   optReg <= OPT_RESET;
    else if (optWe) optReg <= optWdata;
  end

  // terminal count = 2^(PRE_BITS+sel) - 1
  always_comb begin
    limitW = ({{CNT_W{1'b0}}, 1'b1} << (PRE_BITS + int'(sel))) - 1'b1;
  end

  assign tmo = stb.tickEn && ({1'b0, cnt} >= limitW);

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)                cnt <= '0;
    else if (stb.clrCnt || tmo)  cnt <= '0;
    else if (stb.tickEn)         cnt <= cnt + 1'b1;
  end

  // R2: a clear leaves the count at zero
  p_clr_zero_r2: assert property (@(posedge clk) disable iff (!rstPorN)
    $past(stb.clrCnt) |-> cnt == '0);

  // R2: an accepted tick without clear or time-out advances by one
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rstPorN)
    $past(stb.tickEn && !stb.clrCnt && !tmo) |-> cnt == $past(cnt) + 1'b1);

  // R11: without a tick the count holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstPorN)
    $past(!stb.tickEn && !stb.clrCnt) |-> $stable(cnt));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rstPorN,
  input  logic      srcSel,
  input  logic      subTick,
  input  logic      instrTick,
  input  logic      wdtDisable,
  input  logic      dblClrMode,
  input  logic      clrCmd,
  input  logic      clr1,
  input  logic      clr2,
  input  logic      haltReq,
  input  logic      wakeReq,
  input  logic      extRstReq,
  input  logic      tmo,
  output wdog_stb_t stb,
  output logic      chipRst,
  output logic      warmRst,
  output logic      flagTo,
  output logic      flagPd,
  output logic      halted
);
  logic seen1, seen2;
  logic evtTmo, evtHalt, clearOk, clrDo;

  always_comb begin
    stb.tickEn = !wdtDisable && (srcSel ? (instrTick && !halted) : subTick);
    evtTmo     = tmo && !extRstReq;
    evtHalt    = haltReq && !halted && !extRstReq && !tmo;
    if (dblClrMode) clearOk = (clr1 || seen1) && (clr2 || seen2);
    else            clearOk = clrCmd;
    clrDo      = !wdtDisable && !extRstReq && !tmo && !evtHalt && clearOk;
    stb.clrCnt = extRstReq || evtHalt || clrDo;
  end

  // record of paired clear commands
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      seen1 <= 1'b0;
      seen2 <= 1'b0;
    end else if (extRstReq || tmo || evtHalt || clrDo || !dblClrMode || wdtDisable) begin
      seen1 <= 1'b0;
      seen2 <= 1'b0;
    end else begin
      seen1 <= seen1 || clr1;
      seen2 <= seen2 || clr2;
    end
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      chipRst <= 1'b0;
      warmRst <= 1'b0;
    end else begin
      chipRst <= evtTmo && !halted;
      warmRst <= evtTmo && halted;
    end
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)       halted <= 1'b0;
    else if (extRstReq) halted <= 1'b0;
    else if (evtTmo)    halted <= 1'b0;
    else if (evtHalt)   halted <= 1'b1;
    else if (wakeReq)   halted <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      flagTo <= 1'b0;
      flagPd <= 1'b0;
    end else if (evtTmo) begin
      flagTo <= 1'b1;
    end else if (evtHalt) begin
      flagTo <= 1'b0;
      flagPd <= 1'b1;
    end else if (clrDo) begin
      flagTo <= 1'b0;
    end
  end

  p_one_rst_r4: assert property (@(posedge clk) disable iff (!rstPorN)
    !(chipRst && warmRst));

  p_halt_flags_r5: assert property (@(posedge clk) disable iff (!rstPorN)
    $past(haltReq && !halted && !extRstReq && !tmo) |-> halted && flagPd && !flagTo);

  p_warm_flags_r6: assert property (@(posedge clk) disable iff (!rstPorN)
    warmRst |-> flagTo && flagPd && !halted);

  p_ext_keep_r7: assert property (@(posedge clk) disable iff (!rstPorN)
    $past(extRstReq) |-> !halted && $stable(flagTo) && $stable(flagPd));

  p_dis_quiet_r11: assert property (@(posedge clk) disable iff (!rstPorN)
    $past(wdtDisable) |-> !chipRst && !warmRst);
endmodule

// File: rtl/wdog_cause.sv
module wdog_cause
  import wdog_pkg::*;
#(
  parameter int PRE_BITS = 8,
  parameter int SEL_W    = 3
) (
  input  logic       clk,
  input  logic       rstPorN,
  input  logic       srcSel,
  input  logic       subTick,
  input  logic       instrTick,
  input  logic       wdtDisable,
  input  logic       dblClrMode,
  input  logic       clrCmd,
  input  logic       clr1,
  input  logic       clr2,
  input  logic       haltReq,
  input  logic       wakeReq,
  input  logic       extRstReq,
  input  logic       optWe,
  input  logic [7:0] optWdata,
  output logic [7:0] optRdata,
  output logic       chipRst,
  output logic       warmRst,
  output logic       flagTo,
  output logic       flagPd,
  output logic       halted
);
  wdog_stb_t stb;
  logic      tmo;

  wdog_ctrl u_ctrl (
    .clk(clk), .rstPorN(rstPorN), .srcSel(srcSel), .subTick(subTick),
    .instrTick(instrTick), .wdtDisable(wdtDisable), .dblClrMode(dblClrMode),
    .clrCmd(clrCmd), .clr1(clr1), .clr2(clr2), .haltReq(haltReq),
    .wakeReq(wakeReq), .extRstReq(extRstReq), .tmo(tmo), .stb(stb),
    .chipRst(chipRst), .warmRst(warmRst), .flagTo(flagTo), .flagPd(flagPd),
    .halted(halted)
  );

  wdog_dp #(.PRE_BITS(PRE_BITS), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstPorN(rstPorN), .stb(stb), .optWe(optWe),
    .optWdata(optWdata), .optRdata(optRdata), .tmo(tmo)
  );
endmodule

// File: tb/wdog_cause_tb.sv
module wdog_cause_tb;
  localparam int PB = 3;

  logic clk = 1'b0;
  logic rstPorN = 1'b0;
  logic srcSel = 0, subTick = 0, instrTick = 0, wdtDisable = 0, dblClrMode = 0;
  logic clrCmd = 0, clr1 = 0, clr2 = 0, haltReq = 0, wakeReq = 0, extRstReq = 0;
  logic optWe = 0;
  logic [7:0] optWdata = 8'h00;
  logic [7:0] optRdata;
  logic chipRst, warmRst, flagTo, flagPd, halted;

  int nChecks = 0, nFails = 0, cycles = 0;
  int lastN;
  logic sawChip, sawWarm;

  always #5 clk = ~clk;

  wdog_cause #(.PRE_BITS(PB), .SEL_W(3)) u_dut (
    .clk(clk), .rstPorN(rstPorN), .srcSel(srcSel), .subTick(subTick),
    .instrTick(instrTick), .wdtDisable(wdtDisable), .dblClrMode(dblClrMode),
    .clrCmd(clrCmd), .clr1(clr1), .clr2(clr2), .haltReq(haltReq),
    .wakeReq(wakeReq), .extRstReq(extRstReq), .optWe(optWe),
    .optWdata(optWdata), .optRdata(optRdata), .chipRst(chipRst),
    .warmRst(warmRst), .flagTo(flagTo), .flagPd(flagPd), .halted(halted)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock; strobes drop afterwards; returns at a falling edge
  task automatic cyc();
    @(negedge clk);
    subTick = 0; instrTick = 0; clrCmd = 0; clr1 = 0; clr2 = 0;
    haltReq = 0; wakeReq = 0; extRstReq = 0; optWe = 0;
  endtask

  task automatic tick();
    if (srcSel) instrTick = 1; else subTick = 1;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) begin tick(); cyc(); end
  endtask

  task automatic measure(input int maxN);
    lastN = 0; sawChip = 0; sawWarm = 0;
    for (int i = 0; i < maxN; i++) begin
      tick(); cyc(); lastN++;
      if (chipRst || warmRst) begin
        sawChip = chipRst; sawWarm = warmRst;
        break;
      end
    end
  endtask

  task automatic setOpt(input logic [7:0] v);
    optWe = 1; optWdata = v; cyc();
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstPorN = 1;
    cyc();
    // R1
    chk(!flagTo && !flagPd, "R1 flags", {flagTo, flagPd}, 0);
    chk(optRdata == 8'h07, "R1 option", optRdata, 7);
    chk(!chipRst && !warmRst, "R1 resets", {chipRst, warmRst}, 0);

    // R2 / R4 sweep over select and both sources
    for (int s = 0; s < 2; s++) begin
      for (int sel = 0; sel < 8; sel++) begin
        srcSel = s[0];
        setOpt(8'(sel));
        clrCmd = 1; cyc();
        measure(4096);
        chk(lastN == (1 << (PB + sel)) && sawChip && !sawWarm, "R2 period",
            lastN, 1 << (PB + sel));
        chk(flagTo && !flagPd, "R4 flags after time-out", {flagTo, flagPd}, 2);
        cyc();
        chk(!chipRst, "R4 one-cycle pulse", chipRst, 0);
        clrCmd = 1; cyc();
        chk(!flagTo, "R8 clear drops time-out flag", flagTo, 0);
      end
    end
    srcSel = 0;

    // R3 user bits
    setOpt(8'hA8);
    chk(optRdata == 8'hA8, "R3 readback", optRdata, 8'hA8);
    clrCmd = 1; cyc();
    measure(4096);
    chk(lastN == 8, "R3 period unchanged", lastN, 8);
    setOpt(8'h00);

    // R5 / R6 halt and warm reset
    clrCmd = 1; cyc();
    ticks(3);
    haltReq = 1; cyc();
    chk(halted && flagPd && !flagTo, "R5 halt flags", {halted, flagTo, flagPd}, 5);
    measure(100);
    chk(lastN == 8 && sawWarm && !sawChip, "R6 warm after cleared count", lastN, 8);
    chk(flagTo && flagPd && !halted, "R6 flags 11", {halted, flagTo, flagPd}, 3);

    // R7 external reset in normal run keeps flags, clears count
    ticks(5);
    extRstReq = 1; cyc();
    chk(flagTo && flagPd, "R7 normal ext keeps flags", {flagTo, flagPd}, 3);
    measure(100);
    chk(lastN == 8, "R7 ext clears count", lastN, 8);
    // R7 wake from halt by external reset
    haltReq = 1; cyc();
    extRstReq = 1; cyc();
    chk(!halted && !flagTo && flagPd, "R7 ext wake 01", {halted, flagTo, flagPd}, 1);

    // R12 wake keeps count
    ticks(3);
    haltReq = 1; cyc();
    ticks(2);
    wakeReq = 1; cyc();
    chk(!halted, "R12 wake leaves halt", halted, 0);
    measure(100);
    chk(lastN == 6 && sawChip, "R12 count kept", lastN, 6);

    // R10 instruction source frozen in halt
    srcSel = 1;
    clrCmd = 1; cyc();
    haltReq = 1; cyc();
    ticks(40);
    chk(halted, "R10 no time-out in halt", halted, 1);
    wakeReq = 1; cyc();
    measure(100);
    chk(lastN == 8, "R10 instr ticks ignored in halt", lastN, 8);
    srcSel = 0;

    // R8 single mode ignores paired commands
    extRstReq = 1; cyc();
    ticks(5);
    clr1 = 1; cyc();
    clr2 = 1; cyc();
    measure(100);
    chk(lastN == 3, "R8 clr1/clr2 ignored", lastN, 3);

    // R9 double mode
    dblClrMode = 1;
    extRstReq = 1; cyc();
    ticks(5);
    clr1 = 1; cyc();
    clr1 = 1; cyc();
    measure(100);
    chk(lastN == 3, "R9 repeat ignored", lastN, 3);
    ticks(5);
    clr2 = 1; cyc();
    clr1 = 1; cyc();
    chk(!flagTo, "R9 pair clears time-out flag", flagTo, 0);
    measure(100);
    chk(lastN == 8, "R9 reverse order clears", lastN, 8);
    ticks(5);
    clr1 = 1; cyc();
    ticks(1);
    clr2 = 1; cyc();
    measure(100);
    chk(lastN == 8, "R9 spaced pair clears", lastN, 8);
    ticks(4);
    clrCmd = 1; cyc();
    measure(100);
    chk(lastN == 4, "R9 clrCmd ignored", lastN, 4);
    dblClrMode = 0;

    // R11 disable
    wdtDisable = 1;
    clrCmd = 1; cyc();
    chk(flagTo, "R11 clear no-op on flag", flagTo, 1);
    sawChip = 0;
    for (int i = 0; i < 2000; i++) begin
      tick(); cyc();
      if (chipRst || warmRst) sawChip = 1;
    end
    chk(!sawChip, "R11 no reset while disabled", sawChip, 0);
    wdtDisable = 0;
    measure(100);
    chk(lastN == 8, "R11 count frozen", lastN, 8);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule